// File: doc/BRIEF.md
# Pre-emphasis and Energy-Gated Segment Forwarder

This block sits at the head of a speech feature pipeline. It takes a stream of signed 16-bit audio samples at 8 kHz. It runs each sample through a first-order high-boost filter whose coefficient is 15/16, and forms the coefficient product from one arithmetic shift and two subtractions, with no multiplier. A recording opens on a start pulse and covers a fixed number of input samples, 8000 by default, which is one second of audio.

The filtered samples are gathered into fixed segments, 160 samples by default. Each segment is held in a local buffer while its energy accumulates. The energy is the sum of the squared filtered samples. Once the segment is complete, the energy is compared with a threshold that software writes. A segment that reaches the threshold is replayed downstream as one framed burst. A quieter segment is dropped as silence and produces no output. After the last segment of the recording has been settled, the block raises a single-cycle completion pulse and returns to idle.

Top module: `speech_gate_top`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `rec_done` are low, and they stay low until `rec_start` is pulsed.
- R2: Each accepted input x gives y = x − p + (p >>> 4), where p is the previous accepted input of the same recording and >>> is an arithmetic (floor) shift.
- R3: When y falls outside the signed 16-bit range, it saturates to 32767 or −32768, and the saturated value is what is both squared and forwarded.
- R4: `in_ready` is high only while a segment is being filled, and it is never high in the same cycle as `out_valid`. A segment closes after exactly SEG_LEN input handshakes.
- R5: The energy of a segment is the sum of y² over its SEG_LEN filtered samples. The segment is forwarded when energy ≥ `threshold`, so a threshold equal to the energy passes. The threshold is read in the cycle after the segment closes.
- R6: A segment whose energy is below `threshold` produces no `out_valid`, and `in_ready` returns for the next segment.
- R7: A forwarded segment delivers its SEG_LEN filtered samples in arrival order. `out_sof` is high on the first of them and `out_eof` is high on the last.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sample` hold steady.
- R9: Once the final segment of a recording has been dropped, or fully delivered, `rec_done` is high for exactly one cycle and the block goes back to idle with `in_ready` low.
- R10: The filter history p carries across segment boundaries within a recording, and it is zero for the first sample after `rec_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_start | input | 1 | Opens a recording when idle |
| threshold | input | 40 | Energy level a segment must reach to be forwarded |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_sample | input | 16 | Signed input audio sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output sample |
| out_sample | output | 16 | Signed filtered sample |
| out_sof | output | 1 | First sample of a forwarded segment |
| out_eof | output | 1 | Last sample of a forwarded segment |
| rec_done | output | 1 | One-cycle pulse at the end of a recording |

## Verification
The bench sets the threshold to exactly the energy it computed for a segment, and then to one above it. A comparator that used strict greater-than would drop the first segment, and one that was off by one would forward the second. It drives full-scale swings of opposite sign to force both saturation rails, where a wrapping filter would emit values of the wrong sign. It follows one recording with a second, to catch filter history that is not cleared, and it holds back the first sample of every burst, to catch an output that advances without a handshake. It ends recordings on both a dropped segment and a forwarded one, so a completion pulse that is missing, repeated or early shows up in either case.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrRec;     // new recording: clear filter history
    logic clrEnergy;  // start a fresh energy sum
    logic wrEn;       // accept one input sample
  } sg_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_DECIDE = 2'd2,
    ST_EMIT   = 2'd3
  } sg_state_t;

endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SEG_LEN  = 160,
  parameter int ENERGY_W = 40,
  parameter int IDX_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sg_ctl_t                    ctl,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [IDX_W-1:0]           rdIdx,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  logic [ENERGY_W-1:0]        threshold,
  output logic signed [SAMPLE_W-1:0] outSample,
  output logic                       energyPass
);
  localparam int EXT_W = SAMPLE_W + 2;
  localparam int SQ_W  = 2 * SAMPLE_W;

  logic signed [SAMPLE_W-1:0] prevQ;
  logic signed [SAMPLE_W-1:0] prevSh;
  logic signed [EXT_W-1:0]    diffExt;
  logic signed [SAMPLE_W-1:0] filtSat;
  logic signed [SQ_W-1:0]     sq;
  logic [ENERGY_W-1:0]        energyQ;
  logic signed [SAMPLE_W-1:0] bufMem [SEG_LEN];

  // a*p with a = 15/16 is p - (p >>> 4); so y = x - p + (p >>> 4)
  assign prevSh  = prevQ >>> 4;
  assign diffExt = {{2{inSample[SAMPLE_W-1]}}, inSample}
                 - {{2{prevQ[SAMPLE_W-1]}}, prevQ}
                 + {{2{prevSh[SAMPLE_W-1]}}, prevSh};

  always_comb begin
    if (diffExt[EXT_W-1:SAMPLE_W-1] == '0 || diffExt[EXT_W-1:SAMPLE_W-1] == '1)
      filtSat = diffExt[SAMPLE_W-1:0];
    else if (diffExt[EXT_W-1])
      filtSat = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else
      filtSat = {1'b0, {(SAMPLE_W-1){1'b1}}};
  end

  assign sq = filtSat * filtSat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevQ   <= '0;
      energyQ <= '0;
    end else begin
      if (ctl.clrRec)
        prevQ <= '0;
      else if (ctl.wrEn)
        prevQ <= inSample;
      if (ctl.clrEnergy)
        energyQ <= '0;
      else if (ctl.wrEn)
        energyQ <= energyQ + {{(ENERGY_W-SQ_W){1'b0}}, sq};
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn)
      bufMem[wrIdx] <= filtSat;
  end

  assign outSample  = bufMem[rdIdx];
  assign energyPass = (energyQ >= threshold);

  AST_ENERGY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clrEnergy |=> energyQ >= $past(energyQ)) else $error("energy fell"); // R5

  AST_HISTORY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrRec && !ctl.wrEn |=> prevQ == '0) else $error("history kept"); // R10

endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int SEG_LEN = 160,
  parameter int REC_LEN = 8000,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recStart,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSof,
  output logic             outEof,
  output logic             recDone,
  input  logic             energyPass,
  output sg_ctl_t          ctl,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx
);
  localparam int SEG_CNT = REC_LEN / SEG_LEN;
  localparam int SEGC_W  = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(SEG_LEN - 1);
  localparam logic [SEGC_W-1:0] LAST_SEG = SEGC_W'(SEG_CNT - 1);

  sg_state_t         state;
  logic [SEGC_W-1:0] segCnt;
  logic              doneQ;
  logic              lastSeg;

  assign lastSeg  = (segCnt == LAST_SEG);
  assign inReady  = (state == ST_FILL);
  assign outValid = (state == ST_EMIT);
  assign outSof   = outValid && (rdIdx == '0);
  assign outEof   = outValid && (rdIdx == LAST_IDX);
  assign recDone  = doneQ;

  assign ctl.clrRec    = (state == ST_IDLE) && recStart;
  assign ctl.clrEnergy = ctl.clrRec || (state == ST_DECIDE);
  assign ctl.wrEn      = inReady && inValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wrIdx  <= '0;
      rdIdx  <= '0;
      segCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (recStart) begin
          state  <= ST_FILL;
          wrIdx  <= '0;
          segCnt <= '0;
        end
        ST_FILL: if (ctl.wrEn) begin
          if (wrIdx == LAST_IDX) begin
            wrIdx <= '0;
            state <= ST_DECIDE;
          end else begin
            wrIdx <= wrIdx + 1'b1;
          end
        end
        ST_DECIDE: begin
          if (energyPass) begin
            rdIdx <= '0;
            state <= ST_EMIT;
          end else if (lastSeg) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            segCnt <= segCnt + 1'b1;
            state  <= ST_FILL;
          end
        end
        ST_EMIT: if (outReady) begin
          if (rdIdx == LAST_IDX) begin
            rdIdx <= '0;
            if (lastSeg) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              segCnt <= segCnt + 1'b1;
              state  <= ST_FILL;
            end
          end else begin
            rdIdx <= rdIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(inReady && outValid)) else $error("in/out overlap"); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(rdIdx)) else $error("output moved"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recDone |=> !recDone && !inReady) else $error("done too long"); // R9

  AST_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DECIDE && !energyPass |=> !outValid) else $error("quiet segment sent"); // R6

endmodule

// File: rtl/speech_gate_top.sv
module speech_gate_top #(
  parameter int SAMPLE_W = 16,
  parameter int SEG_LEN  = 160,
  parameter int REC_LEN  = 8000,
  parameter int ENERGY_W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rec_start,
  input  logic [ENERGY_W-1:0] threshold,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_sof,
  output logic                out_eof,
  output logic                rec_done
);
  import sg_pkg::*;

  localparam int IDX_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  sg_ctl_t          ctl;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             energyPass;
  logic signed [SAMPLE_W-1:0] outS;

  sg_ctrl #(.SEG_LEN(SEG_LEN), .REC_LEN(REC_LEN), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .recStart(rec_start),
    .inValid(in_valid), .inReady(in_ready),
    .outValid(out_valid), .outReady(out_ready),
    .outSof(out_sof), .outEof(out_eof), .recDone(rec_done),
    .energyPass(energyPass), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  sg_datapath #(.SAMPLE_W(SAMPLE_W), .SEG_LEN(SEG_LEN),
                .ENERGY_W(ENERGY_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .inSample(in_sample), .threshold(threshold),
    .outSample(outS), .energyPass(energyPass)
  );

  assign out_sample = outS;

endmodule

// File: tb/speech_gate_top_tb_top.sv
module speech_gate_top_tb_top;
  localparam int SEG  = 4;
  localparam int REC  = 12;
  localparam int NSEG = REC / SEG;
  localparam int NREC = 2;

  // Samples for two recordings, three segments each
  localparam int STIM [NREC*REC] = '{
    1000, -2000, 3000, 500,
    -32768, 32767, -32768, 100,
    0, 0, 7, 4000,
    100, -50, 25, 9,
    5, 6, 7, 8,
    200, -300, 32767, 32767 };
  // 0: threshold = energy, 1: energy + 1, 2: zero, 3: all ones
  localparam int MODES [NREC*NSEG] = '{0, 2, 1, 2, 0, 3};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        rec_start = 0;
  logic [39:0] threshold = '0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [15:0] out_sample;
  logic        out_sof, out_eof, rec_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  speech_gate_top #(.SEG_LEN(SEG), .REC_LEN(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .threshold(threshold),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_sof(out_sof), .out_eof(out_eof), .rec_done(rec_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x);
    in_valid  = 1;
    in_sample = 16'(x);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic waitOut(output bit got);
    got = 0;
    for (int i = 0; i < 10; i++) begin
      if (out_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int  prevX;
    int  ys [SEG];
    bit  pass;
    bit  got;
    bit  sawOut;
    int  doneCnt;
    longint energy;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 0, "R1 in_ready", in_ready, 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(rec_done == 0, "R1 rec_done", rec_done, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R1 idle before start", in_ready, 0);

    for (int r = 0; r < NREC; r++) begin
      rec_start = 1;
      @(negedge clk);
      rec_start = 0;
      prevX = 0; // R10: history cleared per recording
      for (int s = 0; s < NSEG; s++) begin
        energy = 0;
        for (int k = 0; k < SEG; k++) begin
          int x, y;
          x = STIM[r*REC + s*SEG + k];
          y = x - prevX + (prevX >>> 4);
          if (y > 32767) y = 32767;
          if (y < -32768) y = -32768;
          ys[k] = y;
          energy += longint'(y) * longint'(y);
          prevX = x;
        end
        case (MODES[r*NSEG + s])
          0: threshold = 40'(energy);
          1: threshold = 40'(energy + 1);
          2: threshold = '0;
          default: threshold = '1;
        endcase
        pass = (MODES[r*NSEG + s] == 0) || (MODES[r*NSEG + s] == 2);
        for (int k = 0; k < SEG; k++) send(STIM[r*REC + s*SEG + k]);
        if (pass) begin
          for (int k = 0; k < SEG; k++) begin
            waitOut(got);
            chk(got, "R5 segment forwarded", got, 1);
            chk($signed(out_sample) == ys[k], "R2 R3 R10 filtered sample", $signed(out_sample), ys[k]);
            chk(out_sof == (k == 0), "R7 sof", out_sof, k == 0);
            chk(out_eof == (k == SEG-1), "R7 eof", out_eof, k == SEG-1);
            chk(in_ready == 0, "R4 no input during output", in_ready, 0);
            if (k == 0) begin
              repeat (2) begin
                @(negedge clk);
                chk(out_valid == 1, "R8 valid held", out_valid, 1);
                chk($signed(out_sample) == ys[0], "R8 data held", $signed(out_sample), ys[0]);
              end
            end
            out_ready = 1;
            @(negedge clk);
            out_ready = 0;
          end
        end else begin
          sawOut = 0;
          for (int i = 0; i < 4; i++) begin
            if (out_valid) sawOut = 1;
            if (in_ready || rec_done) break;
            @(negedge clk);
          end
          chk(!sawOut, "R6 dropped segment silent", sawOut, 0);
        end
        if (s < NSEG-1) begin
          for (int i = 0; i < 4 && !in_ready; i++) @(negedge clk);
          chk(in_ready == 1, "R4 R6 ready for next segment", in_ready, 1);
        end
      end
      doneCnt = 0;
      for (int i = 0; i < 6; i++) begin
        if (rec_done) doneCnt++;
        @(negedge clk);
      end
      chk(doneCnt == 1, "R9 done pulse width", doneCnt, 1);
      chk(in_ready == 0, "R9 idle after done", in_ready, 0);
      chk(out_valid == 0, "R9 no output after done", out_valid, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule